// File: doc/BRIEF.md
# Maskable Real-Time-Clock Alarm Comparator

This block watches a running BCD calendar time and raises an alarm when the time agrees with a set of four programmable alarm fields: seconds, minutes, hours and a day field. Each alarm field carries a "don't care" bit in its top position. When that bit is set, the field is left out of the comparison. Choosing which fields take part gives alarm rates from once every second up to once a month.

The comparison is made only on the cycle in which the one-second tick is high. The time inputs are taken to hold the freshly updated time on that cycle, so each matching second raises the alarm once. A match latches a sticky alarm flag. The flag stays set until software clears it, and the clear works only while register protection is off. An active-low alarm output is the OR of the flag and an alarm input shared with other sources. The hour field may be written in 12-hour or 24-hour form on either side, and the two are compared by the hour they stand for. The day field either compares against day-of-week or against date of month.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, `flag` is 0, and `alarm_n` is 1 while `ext_alarm` is 0.
- R2: When `tick`, `osc_en` and `alarm_en` are all 1 and every unmasked field matches, `flag` is 1 from the next clock edge onward.
- R3: Bit 7 of an alarm register set to 1 excludes that field from the comparison. With all four bits 7 set, every enabled tick sets the flag.
- R4: A matching time with `tick` at 0 never sets `flag`.
- R5: With `osc_en` at 0 or `alarm_en` at 0, a matching tick does not set `flag`.
- R6: Bit 6 of `al_day` at 1 compares `al_day[5:0]` with the day-of-week `tm_wday` (codes 1 to 7). At 0 it compares `al_day[5:0]` with the BCD date `tm_date`.
- R7: For hours, bit 6 selects 12-hour form (1) or 24-hour form (0). In 12-hour form, bit 5 is PM and bits 4:0 are the BCD hour from 1 to 12, where 12 AM means hour 0 and 12 PM means hour 12. The alarm hour and the time hour match when they stand for the same hour of day, whatever form each is written in.
- R8: A `clr` pulse with `prot` at 0 clears `flag` at the next edge. With `prot` at 1, `clr` has no effect.
- R9: When a setting match and an allowed clear fall in the same cycle, the flag ends up set.
- R10: `alarm_n` is 0 exactly when `flag` or `ext_alarm` is 1.
- R11: Once set, `flag` stays 1 through any number of ticks until an allowed clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second tick; the time inputs are valid on this cycle |
| osc_en | input | 1 | Oscillator running enable |
| alarm_en | input | 1 | Clock-alarm enable |
| tm_sec | input | 7 | BCD seconds |
| tm_min | input | 7 | BCD minutes |
| tm_hour | input | 7 | Hour in 12-hour or 24-hour form (R7) |
| tm_wday | input | 3 | Day of week, 1 to 7 |
| tm_date | input | 6 | BCD date of month |
| al_sec | input | 8 | Seconds alarm; bit 7 mask |
| al_min | input | 8 | Minutes alarm; bit 7 mask |
| al_hour | input | 8 | Hours alarm; bit 7 mask |
| al_day | input | 8 | Day alarm; bit 7 mask, bit 6 day/date select |
| clr | input | 1 | Clear request for the alarm flag |
| prot | input | 1 | Register protection; blocks `clr` |
| ext_alarm | input | 1 | Other alarm sources sharing the output |
| flag | output | 1 | Sticky clock-alarm flag |
| alarm_n | output | 1 | Active-low shared alarm output |

## Verification
A setting match and a software clear can land in the same cycle. The clear request then competes with the tick that re-raises the flag. The bench provokes this directly: it pulses `clr` with `prot` low on the same cycle as a fully matching tick, and requires the flag to be set afterwards. Random runs mix clears and matching ticks at high rates, so the same collision recurs, and each outcome is judged against a bench model in which the set has priority.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int FIELD_W = 7;   // value bits below the mask bit
  localparam int N_FIELDS = 4;  // sec, min, hour, day
  localparam int HOUR_IDX = 2;
  localparam int DAY_IDX = 3;

  // Hour of day (0..23) from either 12-hour or 24-hour encoding.
  function automatic logic [4:0] hour_of_day(input logic [6:0] h);
    int t;
    if (h[6]) begin
      t = int'(h[4]) * 10 + int'(h[3:0]);
      if (t == 12) t = 0;
      if (h[5]) t = t + 12;
    end else begin
      t = int'(h[5:4]) * 10 + int'(h[3:0]);
    end
    return 5'(t);
  endfunction
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int TW = rtc_alm_pkg::FIELD_W,
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [TW-1:0] al_val,
  input  logic          al_mask,
  input  logic [TW-1:0] tm_val,
  output logic          hit
);
  logic same;
  generate
    if (IS_HOUR) begin : g_hour
      assign same = (rtc_alm_pkg::hour_of_day(7'(al_val)) ==
                     rtc_alm_pkg::hour_of_day(7'(tm_val)));
    end else begin : g_plain
      assign same = (al_val == tm_val);
    end
  endgenerate
  assign hit = al_mask | same;
endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       osc_en,
  input  logic       alarm_en,
  input  logic [6:0] tm_sec,
  input  logic [6:0] tm_min,
  input  logic [6:0] tm_hour,
  input  logic [2:0] tm_wday,
  input  logic [5:0] tm_date,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  input  logic [7:0] al_day,
  input  logic       clr,
  input  logic       prot,
  input  logic       ext_alarm,
  output logic       flag,
  output logic       alarm_n
);
  logic [FIELD_W:0]   al_arr [N_FIELDS];
  logic [FIELD_W-1:0] tm_arr [N_FIELDS];
  logic [N_FIELDS-1:0] field_hit;
  logic [5:0] day_sel;
  logic all_hit;
  logic fire;
  logic clr_ok;

  assign day_sel = al_day[6] ? {3'b000, tm_wday} : tm_date;

  assign al_arr[0] = al_sec;
  assign al_arr[1] = al_min;
  assign al_arr[HOUR_IDX] = al_hour;
  assign al_arr[DAY_IDX] = {al_day[7], 1'b0, al_day[5:0]};
  assign tm_arr[0] = tm_sec;
  assign tm_arr[1] = tm_min;
  assign tm_arr[HOUR_IDX] = tm_hour;
  assign tm_arr[DAY_IDX] = {1'b0, day_sel};

  generate
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      alm_field_cmp #(.TW(FIELD_W), .IS_HOUR(i == HOUR_IDX)) u_cmp (
        .al_val (al_arr[i][FIELD_W-1:0]),
        .al_mask(al_arr[i][FIELD_W]),
        .tm_val (tm_arr[i]),
        .hit    (field_hit[i])
      );
    end
  endgenerate

  assign all_hit = &field_hit;
  assign fire    = tick & osc_en & alarm_en & all_hit;
  assign clr_ok  = clr & ~prot;

  alm_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fire),
    .clr_i (clr_ok),
    .flag_q(flag)
  );

  assign alarm_n = ~(flag | ext_alarm);
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic osc_en,
  input logic alarm_en,
  input logic fire,
  input logic clr,
  input logic prot,
  input logic ext_alarm,
  input logic flag,
  input logic alarm_n
);
  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag); // R2
  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !tick) |=> !flag); // R4
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(osc_en && alarm_en)) |=> !flag); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !prot && !fire) |=> !flag); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr && !prot) |=> flag); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && (prot || !clr)) |=> flag); // R11
  AST_PIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_n == !(flag || ext_alarm)); // R10
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .osc_en(osc_en),
  .alarm_en(alarm_en), .fire(fire), .clr(clr), .prot(prot),
  .ext_alarm(ext_alarm), .flag(flag), .alarm_n(alarm_n)
);

// File: tb/rtc_alarm_cmp_test.sv
module rtc_alarm_cmp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, osc_en = 1, alarm_en = 1, clr = 0, prot = 0, ext_alarm = 0;
  logic [6:0] tm_sec = 0, tm_min = 0, tm_hour = 0;
  logic [2:0] tm_wday = 3'd1;
  logic [5:0] tm_date = 6'h01;
  logic [7:0] al_sec = 0, al_min = 0, al_hour = 0, al_day = 0;
  logic flag, alarm_n;
  logic m_flag = 1'b0;
  int total = 0, bad = 0;
  int unsigned seed_sink;

  always #4 clk = ~clk;  // 125 MHz

  rtc_alarm_cmp uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_en(osc_en), .alarm_en(alarm_en),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
    .tm_date(tm_date), .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
    .al_day(al_day), .clr(clr), .prot(prot), .ext_alarm(ext_alarm),
    .flag(flag), .alarm_n(alarm_n)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  // Decode an hour register the bench's own way (R7).
  function automatic int dec_hour(input logic [6:0] h);
    int v;
    if (h[6] == 1'b0) return (h[5:4] * 10) + h[3:0];
    v = (h[4] * 10) + h[3:0];
    return (v % 12) + (h[5] ? 12 : 0);
  endfunction

  function automatic logic [6:0] enc_hour(input int h, input bit twelve);
    int h12;
    if (!twelve) return 7'(bcd(h));
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return {1'b1, (h >= 12) ? 1'b1 : 1'b0, bcd(h12)[4:0]};
  endfunction

  function automatic bit exp_match();
    bit s, m, h, d;
    s = al_sec[7] || (al_sec[6:0] == tm_sec);
    m = al_min[7] || (al_min[6:0] == tm_min);
    h = al_hour[7] || (dec_hour(al_hour[6:0]) == dec_hour(tm_hour));
    if (al_day[6]) d = al_day[7] || (al_day[5:0] == {3'b000, tm_wday});
    else           d = al_day[7] || (al_day[5:0] == tm_date);
    return s && m && h && d;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: update the model, pass the edge, check, drop pulses.
  task automatic step(input string req);
    bit f;
    f = tick && osc_en && alarm_en && exp_match();
    if (f) m_flag = 1'b1;
    else if (clr && !prot) m_flag = 1'b0;
    @(posedge clk); #1;
    chk(req, flag, m_flag);
    chk("R10", alarm_n, ~(m_flag | ext_alarm));
    tick = 0; clr = 0;
  endtask

  task automatic set_time(input int hh, input bit tw, input int mm, input int ss);
    tm_hour = enc_hour(hh, tw); tm_min = 7'(bcd(mm)); tm_sec = 7'(bcd(ss));
  endtask

  task automatic do_clear();
    prot = 0; clr = 1; step("R8");
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd20240611);
    #1;
    chk("R1", flag, 1'b0);
    chk("R1", alarm_n, 1'b1);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", flag, 1'b0);

    // R2: full match on tick
    set_time(12, 0, 34, 56);
    al_sec = 8'h56; al_min = 8'h34; al_hour = 8'h12; al_day = 8'h80;
    step("R4");            // no tick yet: stays 0
    tick = 1; step("R2");
    // R11: sticky through non-matching ticks
    set_time(1, 0, 2, 3);
    repeat (3) begin tick = 1; step("R11"); end
    // R8: clear blocked then allowed
    prot = 1; clr = 1; step("R8");
    do_clear();
    // R5: gated by enables
    set_time(12, 0, 34, 56);
    osc_en = 0; tick = 1; step("R5");
    osc_en = 1; alarm_en = 0; tick = 1; step("R5");
    alarm_en = 1;
    // R3: all masked fires on any tick
    al_sec = 8'h80; al_min = 8'h80; al_hour = 8'h80; al_day = 8'h80;
    set_time(7, 1, 11, 9);
    tick = 1; step("R3");
    do_clear();
    // R3: seconds only unmasked, 30 s per minute
    al_sec = 8'h30; tm_sec = 7'h29; tick = 1; step("R3");
    tm_sec = 7'h30; tick = 1; step("R3");
    do_clear();
    // R6: day-of-week vs date
    al_sec = 8'h80; al_day = 8'h41; tm_wday = 3'd2; tm_date = 6'h01;
    tick = 1; step("R6");
    tm_wday = 3'd1; tm_date = 6'h05; tick = 1; step("R6");
    do_clear();
    al_day = 8'h05; tm_wday = 3'd5; tm_date = 6'h04; tick = 1; step("R6");
    tm_date = 6'h05; tick = 1; step("R6");
    do_clear();
    // R7: hour forms
    al_day = 8'h80; al_hour = 8'h66; tm_hour = 7'h18; tick = 1; step("R7");
    do_clear();
    al_hour = 8'h52; tm_hour = 7'h00; tick = 1; step("R7");
    do_clear();
    al_hour = 8'h52; tm_hour = 7'h12; tick = 1; step("R7");
    al_hour = 8'h12; tm_hour = 7'h72; tick = 1; step("R7");
    do_clear();
    // R9: set and clear together
    prot = 0; clr = 1; tick = 1; step("R9");
    do_clear();
    // R10: external source alone
    ext_alarm = 1; step("R10");
    ext_alarm = 0; step("R10");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      int hh, mm, ss, wd, dt;
      hh = $urandom_range(23); mm = $urandom_range(59); ss = $urandom_range(59);
      wd = $urandom_range(7, 1); dt = $urandom_range(31, 1);
      set_time(hh, $urandom_range(1), mm, ss);
      tm_wday = 3'(wd); tm_date = 6'(bcd(dt));
      al_sec = ($urandom_range(3) != 0) ? {1'b0, tm_sec} : bcd($urandom_range(59));
      al_min = ($urandom_range(3) != 0) ? {1'b0, tm_min} : bcd($urandom_range(59));
      al_hour = {1'b0, enc_hour(($urandom_range(3) != 0) ? hh : $urandom_range(23),
                                $urandom_range(1))};
      if ($urandom_range(1) == 1)
        al_day = {2'b01, 3'b000, ($urandom_range(3) != 0) ? 3'(wd) : 3'($urandom_range(7, 1))};
      else
        al_day = {2'b00, ($urandom_range(3) != 0) ? 6'(bcd(dt)) : 6'(bcd($urandom_range(31, 1)))};
      if ($urandom_range(3) == 0) al_sec[7] = 1;
      if ($urandom_range(3) == 0) al_min[7] = 1;
      if ($urandom_range(3) == 0) al_hour[7] = 1;
      if ($urandom_range(3) == 0) al_day[7] = 1;
      tick = 1'($urandom_range(1));
      osc_en = ($urandom_range(7) != 0);
      alarm_en = ($urandom_range(7) != 0);
      clr = ($urandom_range(3) == 0);
      prot = ($urandom_range(3) == 0);
      ext_alarm = ($urandom_range(15) == 0);
      step("R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule